// File: doc/BRIEF.md
# Raster Sync Timing Generator with External Lock

This block produces raster timing from a single video clock. A horizontal counter steps once per video-clock cycle and a line counter steps once per line. Comparing these counters with programmed points gives active-low horizontal and vertical sync and active-high horizontal and vertical blanking.

Each sync line can be used in one of two ways. It can be an output driven from the counters, or it can be an input that locks the counters to an external timing master. As an input, a falling edge loads the matching counter with a programmed reload value. That value absorbs the fixed two-flop synchroniser latency and any external pipelining. Each sync has its own pin-in, pin-out and output-enable lines.

All settings come in through a simple write port. A direction change waits for the next line or frame start, so no shortened sync pulse appears at the pin.

Top module: `raster_sync_gen`

## Requirements
- R1: While reset is asserted and straight after it, both output enables are low (both syncs are inputs), and both counters read 0.
- R2: The register map is: 0 horizontal total, 1 horizontal sync end, 2 horizontal blank start, 3 horizontal blank end, 4 vertical total, 5 vertical sync end, 6 vertical blank start, 7 vertical blank end, 8 control, 9 horizontal reload, 10 vertical reload. `hs_out` is low exactly while `h_count` < horizontal sync end. `vs_out` is low exactly while `v_count` < vertical sync end.
- R3: `h_count` increases by one each clock. In the clock after it has reached or passed the horizontal total, it returns to 0.
- R4: On each line start, `v_count` increases by one. A line start is either a horizontal wrap or an external horizontal reload. A line start at which `v_count` has reached or passed the vertical total returns `v_count` to 0.
- R5: `h_blank` is high when `h_count` >= blank start or `h_count` < blank end. `v_blank` follows the same rule using `v_count` and the vertical points.
- R6: Control bit 0 selects horizontal sync as an input and bit 1 selects vertical sync as an input (1 = input, output enable low). A new horizontal direction takes effect at the next line start. A new vertical direction takes effect at the next frame start.
- R7: In input mode, a falling edge on `hs_in` sampled at clock edge k makes `h_count` equal the horizontal reload value after edge k+2. The count then goes on from there.
- R8: In input mode, a falling edge on `vs_in` sampled at clock edge k makes `v_count` equal the vertical reload value after edge k+2. This reload takes priority over a line-start advance.
- R9: In output mode, edges on the sync input pin have no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW | Register write data |
| hs_in | input | 1 | External horizontal sync (active low) |
| hs_out | output | 1 | Generated horizontal sync (active low) |
| hs_oe | output | 1 | Horizontal sync output enable |
| vs_in | input | 1 | External vertical sync (active low) |
| vs_out | output | 1 | Generated vertical sync (active low) |
| vs_oe | output | 1 | Vertical sync output enable |
| h_blank | output | 1 | Horizontal blanking (active high) |
| v_blank | output | 1 | Vertical blanking (active high) |
| h_count | output | HW | Horizontal counter |
| v_count | output | VW | Line counter |

## Verification
The assertions check four things on every cycle:
- the horizontal counter steps by one except at a line start;
- the line counter changes only at a line start or an external vertical reload;
- each output enable changes only at its line or frame boundary;
- an external edge always lands the counter on the reload value.

Only the bench's scenarios can show the rest. That covers the exact sync and blanking widths for several programmed geometries, and the three-edge latency measured from the pin. It also covers the direction change landing precisely at the wrap, and that sync edges are ignored in output mode.

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hs_in,
  output logic          hs_out,
  output logic          hs_oe,
  input  logic          vs_in,
  output logic          vs_out,
  output logic          vs_oe,
  output logic          h_blank,
  output logic          v_blank,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count
);

  logic [HW-1:0] h_cnt, h_tot, h_se, h_bs, h_be, h_rl;
  logic [VW-1:0] v_cnt, v_tot, v_se, v_bs, v_be, v_rl;
  logic          hs_req, vs_req, hs_inp, vs_inp;
  logic [2:0]    hs_sy, vs_sy;
  logic          pv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_tot <= '0; h_se <= '0; h_bs <= '0; h_be <= '0; h_rl <= '0;
      v_tot <= '0; v_se <= '0; v_bs <= '0; v_be <= '0; v_rl <= '0;
      hs_req <= 1'b1; vs_req <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0:  h_tot <= wr_data[HW-1:0];
        4'd1:  h_se  <= wr_data[HW-1:0];
        4'd2:  h_bs  <= wr_data[HW-1:0];
        4'd3:  h_be  <= wr_data[HW-1:0];
        4'd4:  v_tot <= wr_data[VW-1:0];
        4'd5:  v_se  <= wr_data[VW-1:0];
        4'd6:  v_bs  <= wr_data[VW-1:0];
        4'd7:  v_be  <= wr_data[VW-1:0];
        4'd8:  {vs_req, hs_req} <= wr_data[1:0];
        4'd9:  h_rl  <= wr_data[HW-1:0];
        4'd10: v_rl  <= wr_data[VW-1:0];
        default: ;
      endcase
    end
  end

  wire h_fall      = hs_inp & hs_sy[2] & ~hs_sy[1];
  wire v_fall      = vs_inp & vs_sy[2] & ~vs_sy[1];
  wire h_wrap      = ~h_fall & (h_cnt >= h_tot);
  wire line_start  = h_wrap | h_fall;
  wire v_end       = v_cnt >= v_tot;
  wire frame_start = (line_start & v_end) | v_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_sy  <= '1;
      vs_sy  <= '1;
      h_cnt  <= '0;
      v_cnt  <= '0;
      hs_inp <= 1'b1;
      vs_inp <= 1'b1;
      pv     <= 1'b0;
    end else begin
      pv    <= 1'b1;
      hs_sy <= {hs_sy[1:0], hs_in};
      vs_sy <= {vs_sy[1:0], vs_in};

      if (h_fall)      h_cnt <= h_rl;
      else if (h_wrap) h_cnt <= '0;
      else             h_cnt <= h_cnt + 1'b1;

      if (v_fall)          v_cnt <= v_rl;
      else if (line_start) v_cnt <= v_end ? '0 : v_cnt + 1'b1;

      if (line_start)  hs_inp <= hs_req;
      if (frame_start) vs_inp <= vs_req;
    end
  end

  assign hs_out  = ~(h_cnt < h_se);
  assign vs_out  = ~(v_cnt < v_se);
  assign hs_oe   = ~hs_inp;
  assign vs_oe   = ~vs_inp;
  assign h_blank = (h_cnt >= h_bs) | (h_cnt < h_be);
  assign v_blank = (v_cnt >= v_bs) | (v_cnt < v_be);
  assign h_count = h_cnt;
  assign v_count = v_cnt;

  a_r3_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(!line_start) |-> h_cnt == HW'($past(h_cnt) + 1'b1));

  a_r7_h_reload: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(h_fall) |-> h_cnt == $past(h_rl));

  a_r8_v_reload: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(v_fall) |-> v_cnt == $past(v_rl));

  a_r4_v_moves_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$stable(v_cnt) |-> $past(line_start || v_fall));

  a_r6_hs_dir_at_line: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$stable(hs_oe) |-> $past(line_start));

  a_r6_vs_dir_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$stable(vs_oe) |-> $past(frame_start));

endmodule

// File: tb/tb_raster_sync_gen.sv
module tb_raster_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12, VW = 11, DW = 16;

  // total, sync end, blank start, blank end, expected sync-low cycles, expected blank cycles
  localparam int NV = 4;
  localparam int VEC [NV][6] = '{
    '{ 9, 2,  8, 1, 2, 3},
    '{15, 4, 12, 2, 4, 6},
    '{ 7, 0,  8, 0, 0, 0},
    '{ 5, 6,  0, 0, 6, 6}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, hs_in = 1, vs_in = 1;
  logic [3:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic hs_out, hs_oe, vs_out, vs_oe, h_blank, v_blank;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_sync_gen #(.HW(HW), .VW(VW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_in(hs_in), .hs_out(hs_out), .hs_oe(hs_oe),
    .vs_in(vs_in), .vs_out(vs_out), .vs_oe(vs_oe),
    .h_blank(h_blank), .v_blank(v_blank), .h_count(h_count), .v_count(v_count));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_h(input int h);
    do step(); while (int'(h_count) != h);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lo, bl;
    repeat (3) @(posedge clk);
    #1;
    chk(hs_oe == 0 && vs_oe == 0, "R1 oe in reset", {hs_oe, vs_oe}, 0);
    chk(h_count == 0 && v_count == 0, "R1 counters in reset", int'(h_count) + int'(v_count), 0);
    @(negedge clk); rst_n = 1;
    step();
    chk(hs_oe == 0 && vs_oe == 0, "R1 oe after reset", {hs_oe, vs_oe}, 0);

    wr(8, 0);
    step();
    chk(hs_oe == 1 && vs_oe == 1, "R6 output mode", {hs_oe, vs_oe}, 3);

    for (int k = 0; k < NV; k++) begin
      wr(0, VEC[k][0]); wr(1, VEC[k][1]); wr(2, VEC[k][2]); wr(3, VEC[k][3]);
      wait_h(0);
      lo = 0; bl = 0;
      for (int i = 0; i <= VEC[k][0]; i++) begin
        if (!hs_out) lo++;
        if (h_blank) bl++;
        step();
      end
      chk(lo == VEC[k][4], "R2 hsync width", lo, VEC[k][4]);
      chk(bl == VEC[k][5], "R5 hblank width", bl, VEC[k][5]);
      chk(h_count == 0, "R3 wrap to zero", int'(h_count), 0);
    end

    wr(0, 9); wr(1, 2); wr(2, 8); wr(3, 1);
    wr(4, 5); wr(5, 2); wr(6, 4); wr(7, 1);
    do step(); while (!(h_count == 9 && v_count == 5));
    step();
    chk(h_count == 0 && v_count == 0, "R4 frame wrap", int'(v_count), 0);
    chk(vs_out == 0, "R2 vsync low line 0", vs_out, 0);
    chk(v_blank == 1, "R5 vblank line 0", v_blank, 1);
    step();
    chk(h_count == 1, "R3 step", int'(h_count), 1);
    wait_h(9);
    step();
    chk(v_count == 1, "R4 line advance", int'(v_count), 1);
    chk(v_blank == 0, "R5 vblank line 1", v_blank, 0);
    chk(vs_out == 0, "R2 vsync low line 1", vs_out, 0);
    wait_h(9);
    step();
    chk(v_count == 2 && vs_out == 1, "R2 vsync high line 2", vs_out, 1);

    wr(9, 7);
    wait_h(1);
    hs_in = 0;
    repeat (3) step();
    chk(h_count == 4, "R9 edge ignored in output mode", int'(h_count), 4);
    hs_in = 1;
    repeat (4) step();

    wait_h(3);
    wr(8, 1);
    wait_h(9);
    chk(hs_oe == 1, "R6 direction held until wrap", hs_oe, 1);
    step();
    chk(h_count == 0 && hs_oe == 0, "R6 direction at wrap", hs_oe, 0);

    wr(9, 5);
    wait_h(1);
    hs_in = 0;
    repeat (2) step();
    chk(h_count == 3, "R7 no early reload", int'(h_count), 3);
    step();
    chk(h_count == 5, "R7 reload value", int'(h_count), 5);
    step();
    chk(h_count == 6, "R7 count continues", int'(h_count), 6);
    hs_in = 1;
    repeat (4) step();

    wr(10, 3);
    wr(8, 3);
    do step(); while (vs_oe != 0);
    wait_h(2);
    vs_in = 0;
    repeat (3) step();
    chk(v_count == 3, "R8 line reload", int'(v_count), 3);
    step();
    chk(v_count == 3 && vs_oe == 0, "R8 holds after reload", int'(v_count), 3);
    vs_in = 1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule